// File: doc/BRIEF.md
# Row-Pair Carry-Chain Unsigned Multiplier

This block multiplies an unsigned multiplier operand X of `XW` bits by an unsigned multiplicand Y of `YW` bits. It returns the full `XW+YW`-bit product. The adder array has one row per pair of adjacent multiplier bits, not one row per bit, so the array has half as many rows. Row k takes bits `x[2k]` and `x[2k+1]` and forms `(2*x[2k+1] + x[2k]) * Y` on a single ripple carry chain.

Cell j of a row first XORs two AND terms: `x[2k]&y[j]` and `x[2k+1]&y[j-1]`. That XOR is one small lookup function per cell. Its result then enters a sum-and-carry stage with the incoming chain carry. Cell 0 has no lower multiplicand bit, and the top cell has no `y[YW]`, so both missing terms are zero. The chain starts with a carry of zero. Each row yields `YW+2` bits: its final carry on top of `YW+1` sum bits.

The rows are weighted by `4^k` and added along a ripple chain of adders. When `XW` is odd, X is widened with a zero at the top. A parameter chooses a purely combinational output or a registered output that has an asynchronous active-low clear.

Top module: `pairRowMult`

## Requirements
- R1: `prodOut` equals the unsigned product `xIn * yIn`, with all `XW+YW` bits kept, for every input pair.
- R2: Suppose the only set bits of `xIn` are bits 2k and 2k+1. Then the product is `(2*xIn[2k+1] + xIn[2k]) * yIn * 4^k`, for every row index k.
- R3: With an odd `XW`, the missing top bit of the last row pair counts as zero, and R1 still holds.
- R4: With `REG_OUT = 0`, `prodOut` follows the inputs with no clock edge in between.
- R5: With `REG_OUT = 1`, `prodOut` takes the product of the inputs present at each rising edge of `clk`. It holds that value while the inputs change between edges.
- R6: With `REG_OUT = 1`, driving `rstN` low clears `prodOut` to 0 without waiting for a clock edge.
- R7: All-ones operands give `(2^XW - 1) * (2^YW - 1)`. This value needs the final carry of the top row.
- R8: R1 holds for operands of unequal widths, such as a 6-bit X and a 10-bit Y.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rstN | input | 1 | Asynchronous active-low clear of the output register |
| xIn | input | XW | Unsigned multiplier operand |
| yIn | input | YW | Unsigned multiplicand operand |
| prodOut | output | XW+YW | Unsigned product |

## Verification
On every clock edge, the assertions check two things. First, each row's output must equal its pair weight times Y and stay within `3*(2^YW-1)`. Second, the output must match an arithmetic product, either at once or one edge later, depending on `REG_OUT`.

Some behaviour shows only in the bench's scenarios. These include the asynchronous clear, the output holding between edges, the padding of an odd-width X, and the all-ones carry corner. The bench covers them with an exhaustive sweep of a 4x4 instance and a 5x3 instance, plus random operands on the 8x8 registered instance and the 6x10 instance.

// File: rtl/pairMultPkg.sv
package pairMultPkg;
  // Width of the multiplier operand after padding to an even count.
  function automatic int evenWidth(input int n);
    return n + (n % 2);
  endfunction
endpackage

// File: rtl/pairRow.sv
// One row: (2*xHi + xLo) * Y on a single ripple carry chain.
module pairRow #(
  parameter int YW = 8
) (
  input  logic          xLo,
  input  logic          xHi,
  input  logic [YW-1:0] yIn,
  output logic [YW+1:0] rowOut
);
  localparam int CELLS = YW + 1;

  // yExt[j+1] holds y[j]; yExt[0] stands for y[-1] and yExt[YW+1] for y[YW].
  logic [YW+1:0] yExt;
  logic [CELLS:0] carry;
  logic [CELLS-1:0] sumBit;

  assign yExt = {1'b0, yIn, 1'b0};
  assign carry[0] = 1'b0;

  for (genvar j = 0; j < CELLS; j++) begin : g_cell
    logic termLo, termHi, lutOut;
    assign termLo = xLo & yExt[j+1];
    assign termHi = xHi & yExt[j];
    // lookup stage: XOR of the two AND terms
    assign lutOut = termLo ^ termHi;
    // carry stage: sum and majority carry
    assign sumBit[j]   = lutOut ^ carry[j];
    assign carry[j+1]  = lutOut ? carry[j] : termLo;
  end

  assign rowOut = {carry[CELLS], sumBit};
endmodule

// File: rtl/rowAccumulate.sv
// Ripple chain of adders summing rows weighted by 4^k.
module rowAccumulate #(
  parameter int YW   = 8,
  parameter int ROWS = 4,
  parameter int PW   = 16
) (
  input  logic [ROWS-1:0][YW+1:0] rowsIn,
  output logic [PW-1:0]           sumOut
);
  logic [PW-1:0] partial [ROWS+1];

  assign partial[0] = '0;

  for (genvar k = 0; k < ROWS; k++) begin : g_add
    logic [PW-1:0] term;
    assign term = PW'(rowsIn[k]) << (2 * k);
    assign partial[k+1] = partial[k] + term;
  end

  assign sumOut = partial[ROWS];
endmodule

// File: rtl/pairRowMult.sv
module pairRowMult
  import pairMultPkg::*;
#(
  parameter int XW      = 8,
  parameter int YW      = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [XW-1:0]    xIn,
  input  logic [YW-1:0]    yIn,
  output logic [XW+YW-1:0] prodOut
);
  localparam int PXW  = evenWidth(XW);
  localparam int ROWS = PXW / 2;
  localparam int RW   = YW + 2;
  localparam int PW   = XW + YW;

  logic [PXW-1:0]          xPad;
  logic [ROWS-1:0][RW-1:0] rowRes;
  logic [PW-1:0]           combProd;
  logic [PW-1:0]           refProd;

  assign xPad = PXW'(xIn);

  for (genvar k = 0; k < ROWS; k++) begin : g_row
    pairRow #(.YW(YW)) u_row (
      .xLo   (xPad[2*k]),
      .xHi   (xPad[2*k+1]),
      .yIn   (yIn),
      .rowOut(rowRes[k])
    );

    logic [RW-1:0] rowRef;
    assign rowRef = RW'({xPad[2*k+1], xPad[2*k]}) * RW'(yIn);

    // R2
    row_value_chk: assert property (@(posedge clk) disable iff (!rstN)
      rowRes[k] == rowRef)
      else $error("row %0d value mismatch", k);

    // R7
    row_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      rowRes[k] <= RW'(3) * RW'({YW{1'b1}}))
      else $error("row %0d exceeds range", k);
  end

  rowAccumulate #(.YW(YW), .ROWS(ROWS), .PW(PW)) u_acc (
    .rowsIn(rowRes),
    .sumOut(combProd)
  );

  assign refProd = PW'(xIn) * PW'(yIn);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prodOut <= '0;
      else       prodOut <= combProd;
    end

    // R5
    prod_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> prodOut == $past(refProd))
      else $error("registered product mismatch");
  end else begin : g_comb
    assign prodOut = combProd;

    // R4
    prod_comb_chk: assert property (@(posedge clk) disable iff (!rstN)
      prodOut == refProd)
      else $error("combinational product mismatch");

    // R1
    zero_operand_chk: assert property (@(posedge clk) disable iff (!rstN)
      (xIn == '0 || yIn == '0) |-> prodOut == '0)
      else $error("zero operand gave nonzero product");
  end
endmodule

// File: tb/test_pairRowMult.sv
module test_pairRowMult;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  int checks = 0;
  int errors = 0;

  always #4ns clk = ~clk;

  // 8x8 registered (defaults)
  logic [7:0]  xA, yA;
  logic [15:0] pA;
  // 4x4 combinational
  logic [3:0]  xB, yB;
  logic [7:0]  pB;
  // 5x3 combinational (odd X width)
  logic [4:0]  xC;
  logic [2:0]  yC;
  logic [7:0]  pC;
  // 6x10 combinational
  logic [5:0]  xD;
  logic [9:0]  yD;
  logic [15:0] pD;

  pairRowMult i_pairRowMult (.clk(clk), .rstN(rstN), .xIn(xA), .yIn(yA), .prodOut(pA));
  pairRowMult #(.XW(4), .YW(4),  .REG_OUT(1'b0)) i_mult44  (.clk(clk), .rstN(rstN), .xIn(xB), .yIn(yB), .prodOut(pB));
  pairRowMult #(.XW(5), .YW(3),  .REG_OUT(1'b0)) i_mult53  (.clk(clk), .rstN(rstN), .xIn(xC), .yIn(yC), .prodOut(pC));
  pairRowMult #(.XW(6), .YW(10), .REG_OUT(1'b0)) i_mult610 (.clk(clk), .rstN(rstN), .xIn(xD), .yIn(yD), .prodOut(pD));

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    #(8ns * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    xA = '0; yA = '0; xB = '0; yB = '0; xC = '0; yC = '0; xD = '0; yD = '0;
    repeat (3) @(posedge clk);
    #1ns;
    // R6: register clear while reset is held
    check("R6 reset state", pA, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R1 R4: exhaustive 4x4, result settles without a clock edge
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        @(negedge clk);
        xB = 4'(a); yB = 4'(b);
        #1ns;
        check("R1 R4 4x4", pB, a * b);
      end
    end

    // R3: exhaustive 5x3, odd X width
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 8; b++) begin
        @(negedge clk);
        xC = 5'(a); yC = 3'(b);
        #1ns;
        check("R3 5x3", pC, a * b);
      end
    end

    // R2: a single row pair active on the 8x8 instance
    for (int k = 0; k < 4; k++) begin
      for (int w = 1; w < 4; w++) begin
        @(negedge clk);
        xA = 8'(w << (2 * k)); yA = 8'hB7;
        @(posedge clk); #1ns;
        check("R2 row pair", pA, longint'(w) * 183 * (longint'(1) << (2 * k)));
      end
    end

    // R7: all-ones operands on every size
    @(negedge clk);
    xA = 8'hFF; yA = 8'hFF; xB = 4'hF; yB = 4'hF; xC = 5'h1F; yC = 3'h7;
    xD = 6'h3F; yD = 10'h3FF;
    #1ns;
    check("R7 4x4 max", pB, 225);
    check("R7 5x3 max", pC, 217);
    check("R7 6x10 max", pD, 63 * 1023);
    @(posedge clk); #1ns;
    check("R7 8x8 max", pA, 255 * 255);

    // R5: registered output holds between edges
    @(negedge clk);
    xA = 8'd3; yA = 8'd5;
    #1ns;
    check("R5 hold before edge", pA, 255 * 255);
    @(posedge clk); #1ns;
    check("R5 update at edge", pA, 15);

    // R1 R5: random 8x8 registered
    for (int n = 0; n < 2000; n++) begin
      int a, b;
      a = int'($urandom_range(255));
      b = int'($urandom_range(255));
      @(negedge clk);
      xA = 8'(a); yA = 8'(b);
      @(posedge clk); #1ns;
      check("R1 R5 8x8", pA, a * b);
    end

    // R8: random 6x10
    for (int n = 0; n < 2000; n++) begin
      int a, b;
      a = int'($urandom_range(63));
      b = int'($urandom_range(1023));
      @(negedge clk);
      xD = 6'(a); yD = 10'(b);
      #1ns;
      check("R8 6x10", pD, a * b);
    end

    // R6: asynchronous clear mid-run
    @(negedge clk);
    xA = 8'd200; yA = 8'd100;
    @(posedge clk); #1ns;
    check("R6 preload", pA, 20000);
    @(negedge clk);
    rstN = 1'b0;
    #1ns;
    check("R6 async clear", pA, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1ns;
    check("R6 resume after clear", pA, 20000);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule